// File: doc/BRIEF.md
# Low-Speed Clock Source Selector

This block produces the low-speed clock that a timekeeping domain runs from. It picks one of two sources, an internal RC oscillator (the block clock `clk`) or an external crystal oscillator (`ext_osc_i`). It also drives the enable for the external oscillator and gates a copy of the chosen clock out to a pin. The internal path is slowed by a fixed pre-divider of `PRE_DIV` and then by a programmable ratio of (N+1). N is a 5-bit field set by software. The external path bypasses both dividers.

The control word is guarded: it changes only when the write carries a 16-bit unlock key in its upper half. The external clock is watched. If it stops while it is selected, and the guard bit does not forbid it, the block falls back to the internal source by itself and flags this in a read-only status bit. Everything runs on `clk`. The external clock is brought in through a synchroniser, and the low-speed clock is produced as a registered level.

Registers are word-indexed by `bus_addr`: 0 is the control word, 1 is the prescaler, 2 is the output gate. Any other index reads zero and ignores writes. Reads are combinational.

Top module: `lsclk_select`

## Requirements
- R1: A write to index 0 changes the control word only when `bus_wdata[31:16]` equals 16'h16AA. Any other write leaves the readback of index 0 unchanged.
- R2: With control bit 0 at 0 (internal source), `ls_clk_o` is a square wave with a period of `PRE_DIV*(N+1)` clk cycles. Each of its two phases lasts `PRE_DIV/2*(N+1)` cycles. N is prescaler bits [4:0].
- R3: With control bit 0 at 1 and no fallback active, `ls_clk_o` follows the synchronised external clock at the external period, whatever N is.
- R4: When the external source is selected and bit 15 is 0, an absence of external rising edges for `MISS_LIMIT` clk cycles sets status bit 1 of index 0 and returns `ls_clk_o` to the internal divided clock.
- R5: With control bit 15 at 1, a stopped external clock never sets the status bit, and `ls_clk_o` stays stuck rather than switching.
- R6: `ls_out_o` carries `ls_clk_o` delayed one cycle when bit 0 of index 2 is 1, and it is held low when that bit is 0.
- R7: A new prescaler value takes effect only at the divider terminal count. Every phase of `ls_clk_o` therefore has either the old length or the new length, never a shortened one.
- R8: A keyed control write clears the fallback status and re-arms the watchdog.
- R9: Index 0 reads back bits 0, 4 and 15 as last keyed-written, bit 1 as the fallback status and all other bits as 0. Index 1 reads back only bits [4:0]. `ext_osc_en_o` equals control bit 4. After reset all registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the internal RC source |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Word index of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| ext_osc_i | input | 1 | External oscillator, asynchronous |
| ext_osc_en_o | output | 1 | Enable for the external oscillator |
| ls_clk_o | output | 1 | Selected low-speed clock (registered level) |
| ls_out_o | output | 1 | Gated pin copy of the low-speed clock |

## Verification
Register updates are visible on `bus_rdata` at the first falling edge after the capturing rising edge. The bench reads there. Clock results are checked as phase and period lengths, counted between transitions sampled on falling edges, so the fixed pipeline delays (three synchroniser stages, the mux register and the gate register) drop out of the comparison. For slow effects such as fallback, the bench waits a margin well beyond `MISS_LIMIT` before reading status. After a prescaler change it measures two full periods so that the single allowed old-length phase is tolerated and the next ones must have the new length.

// File: rtl/lsclk_pkg.sv
package lsclk_pkg;
   localparam logic [15:0] UNLOCK_KEY = 16'h16AA;
   localparam int SEL_BIT   = 0;
   localparam int FALL_BIT  = 1;
   localparam int EXTEN_BIT = 4;
   localparam int BYP_BIT   = 15;
   localparam int IDX_CTRL  = 0;
   localparam int IDX_PRESC = 1;
   localparam int IDX_GATE  = 2;

   typedef struct packed {
      logic bypass;
      logic ext_en;
      logic sel;
   } ctrl_t;
endpackage

// File: rtl/lsclk_regs.sv
module lsclk_regs
   import lsclk_pkg::*;
#(
   parameter int ADDR_W  = 4,
   parameter int PRESC_W = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_wr,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [31:0]        bus_wdata,
   input  logic               fallback_i,
   output ctrl_t              ctrl_o,
   output logic [PRESC_W-1:0] presc_o,
   output logic               gate_o,
   output logic               ctrl_wr_ok_o,
   output logic [31:0]        bus_rdata
);
   logic hit_ctrl, hit_presc, hit_gate, key_ok;
   logic wdata_unused;

   assign hit_ctrl  = (bus_addr == ADDR_W'(IDX_CTRL));
   assign hit_presc = (bus_addr == ADDR_W'(IDX_PRESC));
   assign hit_gate  = (bus_addr == ADDR_W'(IDX_GATE));
   assign key_ok    = (bus_wdata[31:16] == UNLOCK_KEY);
   assign ctrl_wr_ok_o = bus_wr && hit_ctrl && key_ok;
   assign wdata_unused = ^bus_wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_o  <= '0;
         presc_o <= '0;
         gate_o  <= 1'b0;
      end else begin
         if (ctrl_wr_ok_o) begin
            ctrl_o.sel    <= bus_wdata[SEL_BIT];
            ctrl_o.ext_en <= bus_wdata[EXTEN_BIT];
            ctrl_o.bypass <= bus_wdata[BYP_BIT];
         end
         if (bus_wr && hit_presc) presc_o <= bus_wdata[PRESC_W-1:0];
         if (bus_wr && hit_gate)  gate_o  <= bus_wdata[0];
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (hit_ctrl) begin
         bus_rdata[SEL_BIT]   = ctrl_o.sel;
         bus_rdata[FALL_BIT]  = fallback_i;
         bus_rdata[EXTEN_BIT] = ctrl_o.ext_en;
         bus_rdata[BYP_BIT]   = ctrl_o.bypass;
      end else if (hit_presc) begin
         bus_rdata[PRESC_W-1:0] = presc_o;
      end else if (hit_gate) begin
         bus_rdata[0] = gate_o;
      end
   end

   // R1: a write without the key must not disturb the control word
   a_r1_key_guard: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && hit_ctrl && !key_ok) |=> $stable(ctrl_o));
endmodule

// File: rtl/lsclk_int_div.sv
module lsclk_int_div #(
   parameter int PRE_DIV = 32,
   parameter int PRESC_W = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [PRESC_W-1:0] presc_i,
   output logic               clk_o
);
   localparam int HALF = PRE_DIV / 2;
   localparam int PCW  = (HALF > 1) ? $clog2(HALF) : 1;

   logic               tick, tc;
   logic [PRESC_W-1:0] div_cnt, cur_div;

   generate
      if (PRE_DIV < 2 || (PRE_DIV % 2) != 0) begin : g_bad_pre
         $error("PRE_DIV must be even and at least 2");
      end
      if (HALF == 1) begin : g_no_pre
         assign tick = 1'b1;
      end else begin : g_pre
         logic [PCW-1:0] pre_cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                           pre_cnt <= '0;
            else if (pre_cnt == PCW'(HALF - 1))   pre_cnt <= '0;
            else                                  pre_cnt <= pre_cnt + 1'b1;
         end
         assign tick = (pre_cnt == PCW'(HALF - 1));
      end
   endgenerate

   assign tc = tick && (div_cnt == cur_div);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_cnt <= '0;
         cur_div <= '0;
         clk_o   <= 1'b0;
      end else if (tc) begin
         div_cnt <= '0;
         cur_div <= presc_i;
         clk_o   <= ~clk_o;
      end else if (tick) begin
         div_cnt <= div_cnt + 1'b1;
      end
   end

   // R7: the active ratio only moves at a terminal count
   a_r7_reload_at_tc: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_div != $past(cur_div)) |-> $past(tc));
   // R2: phase counter never runs past the active ratio
   a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      div_cnt <= cur_div);
endmodule

// File: rtl/lsclk_ext_mon.sv
module lsclk_ext_mon #(
   parameter int MISS_LIMIT = 1024
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ext_i,
   input  logic sel_i,
   input  logic bypass_i,
   input  logic clr_i,
   output logic ext_lvl_o,
   output logic fallback_o
);
   localparam int MCW = $clog2(MISS_LIMIT + 1);

   logic [2:0]     sync_q;
   logic           rise, armed;
   logic [MCW-1:0] miss_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '0;
      else        sync_q <= {sync_q[1:0], ext_i};
   end

   assign rise      = sync_q[1] && !sync_q[2];
   assign ext_lvl_o = sync_q[1];
   assign armed     = sel_i && !bypass_i && !fallback_o;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         miss_cnt   <= '0;
         fallback_o <= 1'b0;
      end else if (clr_i) begin
         miss_cnt   <= '0;
         fallback_o <= 1'b0;
      end else if (!armed || rise) begin
         miss_cnt <= '0;
      end else if (miss_cnt == MCW'(MISS_LIMIT - 1)) begin
         fallback_o <= 1'b1;
         miss_cnt   <= '0;
      end else begin
         miss_cnt <= miss_cnt + 1'b1;
      end
   end

   // R4: fallback only rises while the watchdog was allowed to act
   a_r4_fallback_armed: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fallback_o) |-> $past(sel_i && !bypass_i));
   // R5: with the guard bit set, no fallback can appear
   a_r5_bypass_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (bypass_i && !fallback_o) |=> !fallback_o);
endmodule

// File: rtl/lsclk_select.sv
module lsclk_select
   import lsclk_pkg::*;
#(
   parameter int ADDR_W     = 4,
   parameter int PRESC_W    = 5,
   parameter int PRE_DIV    = 32,
   parameter int MISS_LIMIT = 1024
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic              ext_osc_i,
   output logic              ext_osc_en_o,
   output logic              ls_clk_o,
   output logic              ls_out_o
);
   generate
      if (ADDR_W < 2) begin : g_bad_addr
         $error("ADDR_W must be at least 2");
      end
      if (PRESC_W < 1 || PRESC_W > 16) begin : g_bad_presc
         $error("PRESC_W must be 1..16");
      end
      if (MISS_LIMIT < 2) begin : g_bad_miss
         $error("MISS_LIMIT must be at least 2");
      end
   endgenerate

   ctrl_t              ctrl;
   logic [PRESC_W-1:0] presc;
   logic               gate, ctrl_wr_ok, fallback, ext_lvl, int_clk, use_ext;

   lsclk_regs #(.ADDR_W(ADDR_W), .PRESC_W(PRESC_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .fallback_i(fallback), .ctrl_o(ctrl),
      .presc_o(presc), .gate_o(gate), .ctrl_wr_ok_o(ctrl_wr_ok),
      .bus_rdata(bus_rdata));

   lsclk_int_div #(.PRE_DIV(PRE_DIV), .PRESC_W(PRESC_W)) u_div (
      .clk(clk), .rst_n(rst_n), .presc_i(presc), .clk_o(int_clk));

   lsclk_ext_mon #(.MISS_LIMIT(MISS_LIMIT)) u_mon (
      .clk(clk), .rst_n(rst_n), .ext_i(ext_osc_i), .sel_i(ctrl.sel),
      .bypass_i(ctrl.bypass), .clr_i(ctrl_wr_ok), .ext_lvl_o(ext_lvl),
      .fallback_o(fallback));

   assign use_ext      = ctrl.sel && !fallback;
   assign ext_osc_en_o = ctrl.ext_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ls_clk_o <= 1'b0;
         ls_out_o <= 1'b0;
      end else begin
         ls_clk_o <= use_ext ? ext_lvl : int_clk;
         ls_out_o <= ls_clk_o && gate;
      end
   end

   // R6: pin copy is low in the cycle after the gate was off
   a_r6_gate_off: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(gate) |-> !ls_out_o);
endmodule

// File: tb/lsclk_select_tb.sv
module lsclk_select_tb;
   localparam int TCLK     = 10;
   localparam int PRE_DIV  = 8;
   localparam int MISS     = 40;
   localparam int EXT_HALF = 5;
   localparam logic [31:0] KEY = 32'h16AA_0000;

   logic        clk = 0, rst_n = 0, bus_wr = 0, ext_osc = 0, ext_run = 0;
   logic [3:0]  bus_addr = 0;
   logic [31:0] bus_wdata = 0, bus_rdata;
   logic        ext_en, ls_clk, ls_out;
   int checks = 0, fails = 0;
   bit done = 0;

   always #(TCLK/2) clk = ~clk;

   lsclk_select #(.ADDR_W(4), .PRESC_W(5), .PRE_DIV(PRE_DIV), .MISS_LIMIT(MISS)) u_dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_osc_i(ext_osc),
      .ext_osc_en_o(ext_en), .ls_clk_o(ls_clk), .ls_out_o(ls_out));

   initial forever begin
      repeat (EXT_HALF) @(negedge clk);
      ext_osc = ext_run ? ~ext_osc : 1'b0;
   end

   function automatic int int_half(int n);
      return PRE_DIV / 2 * (n + 1);
   endfunction

   task automatic check(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(int idx, logic [31:0] d);
      @(negedge clk);
      bus_wr = 1; bus_addr = 4'(idx); bus_wdata = d;
      @(negedge clk);
      bus_wr = 0;
   endtask

   task automatic rd(int idx, output logic [31:0] d);
      bus_addr = 4'(idx);
      #1;
      d = bus_rdata;
   endtask

   function automatic logic smp(bit g);
      return g ? ls_out : ls_clk;
   endfunction

   // waits for a rising sample, then measures high time and full period
   task automatic measure(bit g, int limit, output int hi, output int per);
      logic prev, cur;
      int t = 0;
      hi = -1; per = -1;
      @(negedge clk); prev = smp(g);
      forever begin
         @(negedge clk); cur = smp(g); t++;
         if (!prev && cur) break;
         prev = cur;
         if (t > limit) return;
      end
      hi = 0; per = 0; t = 0;
      do begin @(negedge clk); hi++; per++; t++; end while (smp(g) && t < limit);
      do begin @(negedge clk); per++; t++; end while (!smp(g) && t < limit);
      if (t >= limit) begin hi = -1; per = -1; end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog actual=1 expected=0");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      int hi, per, n_cur, cnt;
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R9: reset state
      rd(0, d); check("R9 ctrl reset", int'(d), 0);
      rd(1, d); check("R9 presc reset", int'(d), 0);
      rd(2, d); check("R9 gate reset", int'(d), 0);
      check("R9 ext_en reset", int'(ext_en), 0);
      check("R6 pin reset", int'(ls_out), 0);

      // R1: writes without the key, random upper halves
      for (int i = 0; i < 6; i++) begin
         logic [15:0] k = 16'($urandom);
         if (k == 16'h16AA) k = 16'h0;
         wr(0, {k, 16'h8011});
         rd(0, d); check("R1 keyless write ignored", int'(d), 0);
      end
      wr(0, KEY | 32'h8011);
      rd(0, d); check("R1 keyed write", int'(d), 32'h8011);
      check("R9 ext_en follows bit4", int'(ext_en), 1);
      wr(0, KEY);
      rd(0, d); check("R9 ctrl cleared", int'(d), 0);

      // R9: prescaler mask
      wr(1, 32'hFFFF_FFE3);
      rd(1, d); check("R9 presc mask", int'(d), 3);

      // R2: internal periods for random ratios
      for (int i = 0; i < 6; i++) begin
         n_cur = int'($urandom_range(31, 0));
         wr(1, 32'(n_cur));
         measure(0, 2000, hi, per);
         measure(0, 2000, hi, per);
         check("R2 period", per, 2 * int_half(n_cur));
         check("R2 high phase", hi, int_half(n_cur));
      end

      // R6: gate off then on
      cnt = 0;
      for (int i = 0; i < 300; i++) begin @(negedge clk); if (ls_out) cnt++; end
      check("R6 gated off stays low", cnt, 0);
      wr(2, 32'h1);
      measure(1, 2000, hi, per);
      check("R6 pin period", per, 2 * int_half(n_cur));

      // R7: divider change, old or new phases only
      wr(1, 32'd3);
      measure(0, 2000, hi, per);
      measure(0, 2000, hi, per);
      wr(1, 32'd9);
      measure(0, 2000, hi, per);
      check("R7 first high old or new", int'(hi == int_half(3) || hi == int_half(9)), 1);
      check("R7 first low old or new",
            int'((per - hi) == int_half(3) || (per - hi) == int_half(9)), 1);
      measure(0, 2000, hi, per);
      check("R7 settled period", per, 2 * int_half(9));
      n_cur = 9;

      // R3: external source
      ext_run = 1;
      repeat (20) @(negedge clk);
      wr(0, KEY | 32'h11);
      rd(0, d); check("R3 ctrl ext", int'(d), 32'h11);
      measure(0, 500, hi, per);
      measure(0, 500, hi, per);
      check("R3 ext period", per, 2 * EXT_HALF);
      check("R3 ext high", hi, EXT_HALF);

      // R4: external stops, fallback
      ext_run = 0;
      repeat (MISS + 60) @(negedge clk);
      rd(0, d); check("R4 fallback status", int'(d), 32'h13);
      measure(0, 2000, hi, per);
      measure(0, 2000, hi, per);
      check("R4 internal period after fallback", per, 2 * int_half(n_cur));

      // R8: keyed write re-arms
      ext_run = 1;
      repeat (20) @(negedge clk);
      wr(0, KEY | 32'h11);
      repeat (MISS + 60) @(negedge clk);
      rd(0, d); check("R8 status cleared", int'(d), 32'h11);
      measure(0, 500, hi, per);
      check("R8 ext period again", per, 2 * EXT_HALF);

      // R5: guard bit keeps the external selection
      wr(0, KEY | 32'h8011);
      ext_run = 0;
      repeat (200) @(negedge clk);
      rd(0, d); check("R5 no fallback with guard", int'(d), 32'h8011);
      measure(0, 100, hi, per);
      check("R5 output stuck", per, -1);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule